// File: doc/BRIEF.md
# Adjustable Microframe Start-of-Frame Timer

This block marks the start of each microframe for a USB host controller. A counter runs on the bit-time clock and returns to zero once a full microframe has elapsed. Each return to zero raises a start-of-frame strobe for one cycle. The current count is also available at the ports, so a scheduler can tell how far into the microframe it is.

The microframe length is set by a 6-bit adjustment register. The length is 59488 bit times plus sixteen times the adjustment value, so the reset value of 0x20 gives exactly 60000. Software loads the register through a write-enable port and reads it back on a dedicated output. A simulation-mode input replaces the real-time length with a short fixed length of 64 cycles, so tests of the surrounding logic run quickly.

A new adjustment value or mode does not cut the running microframe short. It is taken up only when the counter next wraps.

Top module: `mframe_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0, `sof` becomes 0 and `adj_q` becomes 0x20. The microframe that follows reset is 60000 cycles long when `sim_mode` is 0 during reset, and 64 cycles long when it is 1.
- R2: Outside reset, `count` rises by one at each clock edge. When it reaches the microframe length minus one, it returns to 0 at the next edge.
- R3: `sof` is high for exactly one cycle. That cycle is the one in which `count` has just wrapped to 0. `sof` is never high after reset alone.
- R4: With `sim_mode` at 0, the length in cycles is 59488 + 16 × `adj_q`. Examples: 0x1F gives 59984, 0x20 gives 60000, 0x3F gives 60496.
- R5: When `adj_we` is high at a clock edge, `adj_wdata[5:0]` appears on `adj_q` after that edge. When `adj_we` is low, `adj_q` keeps its value whatever `adj_wdata` holds.
- R6: The length of a microframe is fixed at the wrap that starts it. It uses the `adj_q` and `sim_mode` values present at that edge. Later changes take effect only from the following wrap.
- R7: With `sim_mode` at 1 when a microframe starts, that microframe is 64 cycles long, whatever the value of `adj_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous active-high reset |
| sim_mode | input | 1 | 1 selects the short 64-cycle simulation length |
| adj_we | input | 1 | Write enable for the adjustment register |
| adj_wdata | input | 6 | Adjustment value to load |
| adj_q | output | 6 | Current adjustment register value |
| count | output | 16 | Position within the current microframe |
| sof | output | 1 | One-cycle start-of-microframe strobe |

## Verification
Three real-time adjustment values are run back to back: the reset default, 0x1F and the maximum 0x3F. Each measured gap between strobes tells apart a wrong base, a wrong step and an off-by-one wrap. Each write is placed in the middle of a microframe, so a design that applies the new length at once gives a gap different from the one a design that waits for the wrap gives. Simulation mode is entered mid-frame with a non-default adjustment, and also from reset. This shows that the short length overrides the adjustment and that the reset-time mode selects the first frame.

// File: rtl/mframe_pkg.sv
package mframe_pkg;

  // Length of one microframe in counter clocks for a given adjustment.
  function automatic int unsigned frame_cycles(input int unsigned base,
                                               input int unsigned step,
                                               input int unsigned adj);
    return base + step * adj;
  endfunction

endpackage

// File: rtl/mframe_adj_reg.sv
module mframe_adj_reg #(
  parameter int ADJ_W     = 6,
  parameter int ADJ_RESET = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ADJ_W-1:0] wdata,
  output logic [ADJ_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= ADJ_W'(ADJ_RESET);
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/mframe_len_sel.sv
module mframe_len_sel
  import mframe_pkg::*;
#(
  parameter int ADJ_W     = 6,
  parameter int CNT_W     = 16,
  parameter int BASE_LEN  = 59488,
  parameter int ADJ_STEP  = 16,
  parameter int ADJ_RESET = 32,
  parameter int SIM_LEN   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sim_mode,
  input  logic [ADJ_W-1:0] adj,
  input  logic             wrap,
  output logic [CNT_W-1:0] last_idx
);

  localparam int RESET_LEN = frame_cycles(BASE_LEN, ADJ_STEP, ADJ_RESET);
  localparam logic [CNT_W-1:0] BASE_LAST  = CNT_W'(BASE_LEN - 1);
  localparam logic [CNT_W-1:0] SIM_LAST   = CNT_W'(SIM_LEN - 1);
  localparam logic [CNT_W-1:0] RESET_LAST = CNT_W'(RESET_LEN - 1);
  localparam bit STEP_POW2 = (ADJ_STEP > 0) && ((ADJ_STEP & (ADJ_STEP - 1)) == 0);
  localparam int STEP_SH   = $clog2(ADJ_STEP > 1 ? ADJ_STEP : 2);

  logic [CNT_W-1:0] scaled_adj;
  logic [CNT_W-1:0] real_last;

  // A power-of-two step is a plain shift; any other step needs a multiplier.
  generate
    if (STEP_POW2 && ADJ_STEP > 1) begin : g_shift
      assign scaled_adj = CNT_W'(adj) << STEP_SH;
    end else begin : g_mult
      assign scaled_adj = CNT_W'(adj) * CNT_W'(ADJ_STEP);
    end
  endgenerate

  assign real_last = BASE_LAST + scaled_adj;

  // Length is sampled only at the wrap edge, so a frame in flight is never resized.
  always_ff @(posedge clk) begin
    if (rst)       last_idx <= sim_mode ? SIM_LAST : RESET_LAST;
    else if (wrap) last_idx <= sim_mode ? SIM_LAST : real_last;
  end

endmodule

// File: rtl/mframe_counter.sv
module mframe_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] count,
  output logic             sof,
  output logic             wrap
);

  assign wrap = (count == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      sof   <= 1'b0;
    end else if (wrap) begin
      count <= '0;
      sof   <= 1'b1;
    end else begin
      count <= count + 1'b1;
      sof   <= 1'b0;
    end
  end

endmodule

// File: rtl/mframe_timer.sv
module mframe_timer #(
  parameter int ADJ_W     = 6,
  parameter int BASE_LEN  = 59488,
  parameter int ADJ_STEP  = 16,
  parameter int ADJ_RESET = 32,
  parameter int SIM_LEN   = 64,
  localparam int MAX_LEN  = BASE_LEN + ADJ_STEP * ((1 << ADJ_W) - 1),
  localparam int CNT_W    = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sim_mode,
  input  logic             adj_we,
  input  logic [ADJ_W-1:0] adj_wdata,
  output logic [ADJ_W-1:0] adj_q,
  output logic [CNT_W-1:0] count,
  output logic             sof
);

  logic [CNT_W-1:0] last_idx;
  logic             wrap;

  mframe_adj_reg #(.ADJ_W(ADJ_W), .ADJ_RESET(ADJ_RESET)) u_adj (
    .clk(clk), .rst(rst), .we(adj_we), .wdata(adj_wdata), .q(adj_q)
  );

  mframe_len_sel #(
    .ADJ_W(ADJ_W), .CNT_W(CNT_W), .BASE_LEN(BASE_LEN), .ADJ_STEP(ADJ_STEP),
    .ADJ_RESET(ADJ_RESET), .SIM_LEN(SIM_LEN)
  ) u_len (
    .clk(clk), .rst(rst), .sim_mode(sim_mode), .adj(adj_q), .wrap(wrap),
    .last_idx(last_idx)
  );

  mframe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .last_idx(last_idx), .count(count), .sof(sof),
    .wrap(wrap)
  );

endmodule

// File: rtl/mframe_timer_chk.sv
module mframe_timer_chk #(
  parameter int ADJ_W     = 6,
  parameter int CNT_W     = 16,
  parameter int ADJ_RESET = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             adj_we,
  input logic [ADJ_W-1:0] adj_wdata,
  input logic [ADJ_W-1:0] adj_q,
  input logic [CNT_W-1:0] count,
  input logic             sof
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0 && !sof && adj_q == ADJ_W'(ADJ_RESET)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count != '0) |-> count == $past(count) + 1'b1);

  assert_sof_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    sof |-> count == '0);

  assert_sof_single_R3: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);

  assert_adj_load_R5: assert property (@(posedge clk) disable iff (rst)
    adj_we |=> adj_q == $past(adj_wdata));

  assert_adj_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !adj_we |=> $stable(adj_q));

endmodule

bind mframe_timer mframe_timer_chk #(
  .ADJ_W(ADJ_W), .CNT_W(CNT_W), .ADJ_RESET(ADJ_RESET)
) u_chk (
  .clk(clk), .rst(rst), .adj_we(adj_we), .adj_wdata(adj_wdata),
  .adj_q(adj_q), .count(count), .sof(sof)
);

// File: tb/test_mframe_timer.sv
module test_mframe_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sim_mode = 1'b0;
  logic        adj_we = 1'b0;
  logic [5:0]  adj_wdata = '0;
  logic [5:0]  adj_q;
  logic [15:0] count;
  logic        sof;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int m_cnt, m_len, m_adj;
  bit m_sof;

  always #2.5 clk = ~clk;

  mframe_timer i_mframe_timer (
    .clk(clk), .rst(rst), .sim_mode(sim_mode), .adj_we(adj_we),
    .adj_wdata(adj_wdata), .adj_q(adj_q), .count(count), .sof(sof)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model: length = 59488 + 16*adj (real) or 64 (sim), fixed at wrap.
  always @(posedge clk) begin
    int old_adj;
    old_adj = m_adj;
    if (rst) begin
      m_cnt = 0; m_sof = 0; m_adj = 32;
      m_len = sim_mode ? 64 : 60000;
    end else begin
      if (adj_we) m_adj = int'(adj_wdata);
      if (m_cnt == m_len - 1) begin
        m_cnt = 0; m_sof = 1;
        m_len = sim_mode ? 64 : 59488 + 16 * old_adj;
      end else begin
        m_cnt = m_cnt + 1; m_sof = 0;
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 count", int'(count), m_cnt);
      check("R3 sof", int'(sof), int'(m_sof));
      check("R5 adj_q", int'(adj_q), m_adj);
    end
  end

  task automatic do_reset(input bit sim);
    @(negedge clk);
    rst = 1'b1; sim_mode = sim;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset count", int'(count), 0);
    check("R1 reset sof", int'(sof), 0);
    check("R1 reset adj", int'(adj_q), 32);
  endtask

  // Count negedges until sof is seen, starting from an already elapsed count.
  task automatic wait_sof(input int start, output int n);
    n = start;
    do begin
      @(negedge clk);
      n++;
    end while (!sof);
  endtask

  task automatic write_adj(input logic [5:0] v);
    adj_we = 1'b1; adj_wdata = v;
    @(negedge clk);
    adj_we = 1'b0; adj_wdata = ~v;
    check("R5 write visible", int'(adj_q), int'(v));
  endtask

  initial begin
    int n;
    do_reset(1'b0);
    // Frame 1: default, write 0x1F mid-frame (must not resize this frame)
    repeat (100) @(negedge clk);
    write_adj(6'h1F);
    @(negedge clk);
    check("R5 no write when we low", int'(adj_q), 31);
    wait_sof(102, n);
    check("R1 R4 R6 default length 60000", n, 60000);
    // Frame 2: 0x1F, write 0x3F mid-frame
    repeat (50) @(negedge clk);
    write_adj(6'h3F);
    wait_sof(51, n);
    check("R4 R6 length for 0x1F", n, 59984);
    // Frame 3: 0x3F, enter sim mode and write 0 mid-frame
    repeat (10) @(negedge clk);
    sim_mode = 1'b1;
    write_adj(6'h00);
    wait_sof(11, n);
    check("R4 R6 length for 0x3F", n, 60496);
    wait_sof(0, n);
    check("R7 sim length", n, 64);
    write_adj(6'h2A);
    wait_sof(1, n);
    check("R7 sim ignores adj", n, 64);
    // Reset with sim mode held high
    do_reset(1'b1);
    wait_sof(0, n);
    check("R1 sim first frame", n, 64);
    wait_sof(0, n);
    check("R7 sim repeat", n, 64);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule